// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-on to a usable state. After a synchronous reset it holds the clock enable low with the command bus idle for the power-up pause. It then raises the clock enable and steps through the fixed bring-up order: precharge of all banks, programming of the three extended mode registers, a mode-register write that resets the DLL, a second precharge, two auto-refreshes, a mode-register write that releases the DLL reset, and the OCD default and OCD exit writes. It then enters normal mode. Each command lasts one cycle and is followed by its own minimum wait, counted in clock cycles. Every wait is derived at elaboration time from a nanosecond parameter and the clock period in picoseconds, and rounded up.

The mode, extended-mode-1 and extended-mode-2 values are configuration inputs. The sequencer inserts the DLL-reset bit and the OCD field itself. When normal mode is entered, `rfsh_en` rises so that the periodic refresh timer downstream may start. After a settle interval `init_done` rises, and the normal controller then owns the bus. The block also reports where the two bank bits sit in a flat system address, computed from the column, row, decode-order and bus-width settings.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `cke`=0, `cmd`=NOP, `rfsh_en`=0 and `init_done`=0.
- R2: After reset release, `cke` stays 0 for exactly W_PWR cycles (it is first seen high W_PWR edges after release). It then stays 1, and no command other than NOP is issued while `cke` is 0.
- R3: `cmd` = {ras_n,cas_n,we_n} is encoded as NOP=3'b111, PRECHARGE=3'b010, REFRESH=3'b001 and MODE-SET=3'b000. Exactly 11 non-NOP commands are issued, in this order: PRE, MRS, MRS, MRS, MRS, PRE, REF, REF, MRS, MRS, MRS.
- R4: The bank address of the mode-set commands is, in order, 2, 3, 1, 0, 0, 1, 1. It is 0 for precharge and refresh.
- R5: The address carries the following values. Both precharges carry only bit 10 set (all banks). Extended register 2 carries `emr2_cfg` and extended register 3 carries zero. The first extended-1 write carries `emr1_cfg` with bits 9:7 (OCD field) cleared. The first mode write carries `mr_cfg` with bit 8 (DLL reset) set, and the second carries it with bit 8 cleared. The OCD-default write has bits 9:7=3'b111 and the OCD-exit write has bits 9:7=3'b000, each with the other bits from `emr1_cfg`. Refresh carries zero.
- R6: Cycles between command issues are as follows: from `cke` rise to the first precharge, W_CKE. After each mode-set and after the first precharge, W_MRD = max(2, ceil(15 ns)). After the extended-1 write that enables the DLL, W_DLL = max(200, W_MRD). After the second precharge, W_PRE (400 ns). After each refresh, W_RFC (400 ns).
- R7: Each command lasts one cycle and the bus shows NOP between commands.
- R8: `rfsh_en` rises W_MRD cycles after the OCD-exit write and `init_done` rises W_SETTLE (10 µs) cycles after that. Both then stay high until reset.
- R9: `bank_pos` = `col_code`+9, plus `row_code`+11 when `seq_map`=1, plus 1 for a full-width bus (`half_bus`=0) or 2 for a half-width bus.
- R10: Once `init_done` is high the bus stays at NOP with `cke`=1. A reset at any point restarts the whole sequence from the power-up pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_code | input | 2 | Column-count code (0..3) |
| row_code | input | 2 | Row-count code (0..3) |
| seq_map | input | 1 | 1 = rows above columns (sequential), 0 = interleaved banks |
| half_bus | input | 1 | 1 = half-width data bus |
| mr_cfg | input | ADDR_W | Mode register value (DLL-reset bit inserted by block) |
| emr1_cfg | input | ADDR_W | Extended register 1 value (OCD field inserted by block) |
| emr2_cfg | input | ADDR_W | Extended register 2 value |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 3 | {ras_n,cas_n,we_n} command |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |
| bank_pos | output | 5 | Lowest bank-bit position in the system address |
| rfsh_en | output | 1 | Normal mode reached; periodic refresh may start |
| init_done | output | 1 | Bring-up complete |

## Verification
Every command output is decoded from registered state, so a step's command is visible one cycle after the edge that enters the step. The bench samples on the falling edge and counts rising edges since reset release. It records the cycle of the `cke` rise, of each non-NOP command, and of the `rfsh_en` and `init_done` rises. It then compares the differences with the exact interval lengths that it rounds up itself from the nanosecond values. `bank_pos` is combinational and is checked one time step after its inputs change.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    localparam int BPOS_W       = 5;
    localparam int DLL_RST_BIT  = 8;
    localparam int OCD_LSB      = 7;
    localparam int PRE_ALL_BIT  = 10;

    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_CKE,
        ST_PRE1,
        ST_EMR2,
        ST_EMR3,
        ST_EMR1_DLL,
        ST_MR_DLLRST,
        ST_PRE2,
        ST_REF1,
        ST_REF2,
        ST_MR_RUN,
        ST_EMR1_OCDDEF,
        ST_EMR1_OCDEXIT,
        ST_NORMAL,
        ST_READY
    } step_e;

    typedef struct packed {
        int unsigned pwr;
        int unsigned cke;
        int unsigned mrd;
        int unsigned pre;
        int unsigned rfc;
        int unsigned dll;
        int unsigned settle;
    } wait_cfg_s;

    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned ps,
                                              int unsigned floor_c);
        longint unsigned num;
        longint unsigned c;
        num = longint'(ns) * 1000;
        c   = (num + longint'(ps) - 1) / longint'(ps);
        if (c < longint'(floor_c)) c = longint'(floor_c);
        return int'(c);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned step_wait(step_e s, wait_cfg_s w);
        case (s)
            ST_PWRUP:        return w.pwr;
            ST_CKE:          return w.cke;
            ST_EMR1_DLL:     return w.dll;
            ST_PRE2:         return w.pre;
            ST_REF1,
            ST_REF2:         return w.rfc;
            ST_NORMAL:       return w.settle;
            default:         return w.mrd;
        endcase
    endfunction

    function automatic int unsigned max_wait(wait_cfg_s w);
        int unsigned m;
        m = max2(w.pwr, w.cke);
        m = max2(m, w.mrd);
        m = max2(m, w.pre);
        m = max2(m, w.rfc);
        m = max2(m, w.dll);
        m = max2(m, w.settle);
        return m;
    endfunction

endpackage

// File: rtl/ddr2_bank_pos.sv
module ddr2_bank_pos
    import ddr2_init_pkg::*;
(
    input  logic [1:0]        col_code,
    input  logic [1:0]        row_code,
    input  logic              seq_map,
    input  logic              half_bus,
    output logic [BPOS_W-1:0] bank_pos
);
    localparam logic [BPOS_W-1:0] COL_BASE = BPOS_W'(9);
    localparam logic [BPOS_W-1:0] ROW_BASE = BPOS_W'(11);

    logic [BPOS_W-1:0] row_part;
    logic [BPOS_W-1:0] bus_part;

    always_comb begin
        row_part = seq_map ? (BPOS_W'(row_code) + ROW_BASE) : '0;
        bus_part = half_bus ? BPOS_W'(2) : BPOS_W'(1);
        bank_pos = BPOS_W'(col_code) + COL_BASE + row_part + bus_part;
    end
endmodule

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/ddr2_step_decode.sv
module ddr2_step_decode
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  step_e             step,
    input  logic              fresh,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr1_cfg,
    input  logic [ADDR_W-1:0] emr2_cfg,
    output logic              cke_o,
    output cmd_e              cmd_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] OCD_MASK = ADDR_W'(7) << OCD_LSB;
    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] PRE_MASK = ADDR_W'(1) << PRE_ALL_BIT;

    logic [ADDR_W-1:0] emr1_base;

    always_comb begin
        emr1_base = emr1_cfg & ~OCD_MASK;
        cke_o  = 1'b1;
        cmd_o  = CMD_NOP;
        ba_o   = 2'd0;
        addr_o = '0;
        case (step)
            ST_PWRUP: cke_o = 1'b0;
            ST_PRE1, ST_PRE2: if (fresh) begin
                cmd_o  = CMD_PRE;
                addr_o = PRE_MASK;
            end
            ST_EMR2: if (fresh) begin
                cmd_o  = CMD_MRS;
                ba_o   = 2'd2;
                addr_o = emr2_cfg;
            end
            ST_EMR3: if (fresh) begin
                cmd_o  = CMD_MRS;
                ba_o   = 2'd3;
            end
            ST_EMR1_DLL, ST_EMR1_OCDEXIT: if (fresh) begin
                cmd_o  = CMD_MRS;
                ba_o   = 2'd1;
                addr_o = emr1_base;
            end
            ST_EMR1_OCDDEF: if (fresh) begin
                cmd_o  = CMD_MRS;
                ba_o   = 2'd1;
                addr_o = emr1_base | OCD_MASK;
            end
            ST_MR_DLLRST: if (fresh) begin
                cmd_o  = CMD_MRS;
                addr_o = mr_cfg | DLL_MASK;
            end
            ST_MR_RUN: if (fresh) begin
                cmd_o  = CMD_MRS;
                addr_o = mr_cfg & ~DLL_MASK;
            end
            ST_REF1, ST_REF2: if (fresh) cmd_o = CMD_REF;
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr2_bringup_seq.sv
module ddr2_bringup_seq
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W        = 14,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int PWRUP_NS      = 200000,
    parameter int CKE_NS        = 400,
    parameter int MRD_NS        = 15,
    parameter int PRE_NS        = 400,
    parameter int RFC_NS        = 400,
    parameter int DLL_LOCK_CYC  = 200,
    parameter int SETTLE_NS     = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        col_code,
    input  logic [1:0]        row_code,
    input  logic              seq_map,
    input  logic              half_bus,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr1_cfg,
    input  logic [ADDR_W-1:0] emr2_cfg,
    output logic              cke,
    output logic [2:0]        cmd,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic [BPOS_W-1:0] bank_pos,
    output logic              rfsh_en,
    output logic              init_done
);
    localparam int unsigned W_MRD = ns_to_cyc(MRD_NS, CLK_PERIOD_PS, 2);
    localparam wait_cfg_s WAITS = '{
        pwr:    ns_to_cyc(PWRUP_NS,  CLK_PERIOD_PS, 2),
        cke:    ns_to_cyc(CKE_NS,    CLK_PERIOD_PS, 2),
        mrd:    W_MRD,
        pre:    ns_to_cyc(PRE_NS,    CLK_PERIOD_PS, 2),
        rfc:    ns_to_cyc(RFC_NS,    CLK_PERIOD_PS, 2),
        dll:    max2(DLL_LOCK_CYC, W_MRD),
        settle: ns_to_cyc(SETTLE_NS, CLK_PERIOD_PS, 2)
    };
    localparam int CNT_W = $clog2(max_wait(WAITS) + 1);

    step_e            step_q;
    step_e            step_nx;
    logic             fresh_q;
    logic             expire;
    logic             advance;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    cmd_e             cmd_dec;

    always_comb begin
        step_nx  = (step_q == ST_READY) ? ST_READY : step_e'(step_q + 4'd1);
        advance  = expire && (step_q != ST_READY);
        tmr_load = rst || advance;
        tmr_val  = rst ? CNT_W'(step_wait(ST_PWRUP, WAITS) - 1)
                       : CNT_W'(step_wait(step_nx, WAITS) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_PWRUP;
            fresh_q <= 1'b1;
        end else if (advance) begin
            step_q  <= step_nx;
            fresh_q <= 1'b1;
        end else begin
            fresh_q <= 1'b0;
        end
    end

    ddr2_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    ddr2_step_decode #(.ADDR_W(ADDR_W)) u_decode (
        .step     (step_q),
        .fresh    (fresh_q),
        .mr_cfg   (mr_cfg),
        .emr1_cfg (emr1_cfg),
        .emr2_cfg (emr2_cfg),
        .cke_o    (cke),
        .cmd_o    (cmd_dec),
        .ba_o     (ba),
        .addr_o   (addr)
    );

    ddr2_bank_pos u_bank_pos (
        .col_code (col_code),
        .row_code (row_code),
        .seq_map  (seq_map),
        .half_bus (half_bus),
        .bank_pos (bank_pos)
    );

    assign cmd       = cmd_dec;
    assign rfsh_en   = (step_q == ST_NORMAL) || (step_q == ST_READY);
    assign init_done = (step_q == ST_READY);
endmodule

// File: rtl/ddr2_bringup_chk.sv
module ddr2_bringup_chk
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic [2:0]        cmd,
    input logic [ADDR_W-1:0] addr,
    input logic              rfsh_en,
    input logic              init_done
);
    logic [3:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (cmd != CMD_NOP) begin
            gap_q  <= 4'd1;
            seen_q <= 1'b1;
        end else if (gap_q != 4'hF) begin
            gap_q  <= gap_q + 4'd1;
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!init_done && !rfsh_en && !cke));

    p_idle_cke_low_r2: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (cmd == CMD_NOP));

    p_cke_hold_r2: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    p_pre_all_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> addr[PRE_ALL_BIT]);

    p_min_gap_r6: assert property (@(posedge clk) disable iff (rst)
        ((cmd != CMD_NOP) && seen_q) |-> (gap_q >= 4'd2));

    p_single_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_rfsh_hold_r8: assert property (@(posedge clk) disable iff (rst)
        rfsh_en |=> rfsh_en);

    p_done_after_rfsh_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> rfsh_en);

    p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cke && cmd == CMD_NOP));
endmodule

bind ddr2_bringup_seq ddr2_bringup_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cmd       (cmd),
    .addr      (addr),
    .rfsh_en   (rfsh_en),
    .init_done (init_done)
);

// File: tb/ddr2_bringup_seq_test.sv
module ddr2_bringup_seq_test;
    localparam int AW        = 14;
    localparam int PS        = 4000;
    localparam int PWR_NS    = 4000;
    localparam int SET_NS    = 2000;
    localparam logic [2:0] NOP = 3'b111, PRE = 3'b010, REF = 3'b001, MRS = 3'b000;

    function automatic int cyc_of(int ns, int lo);
        int c;
        c = (ns * 1000 + PS - 1) / PS;
        return (c < lo) ? lo : c;
    endfunction

    localparam int E_PWR = cyc_of(PWR_NS, 2);
    localparam int E_CKE = cyc_of(400, 2);
    localparam int E_MRD = cyc_of(15, 2);
    localparam int E_PRE = cyc_of(400, 2);
    localparam int E_RFC = cyc_of(400, 2);
    localparam int E_DLL = (E_MRD > 200) ? E_MRD : 200;
    localparam int E_SET = cyc_of(SET_NS, 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] col_code = '0, row_code = '0;
    logic seq_map = 1'b0, half_bus = 1'b0;
    logic [AW-1:0] mr_cfg = '0, emr1_cfg = '0, emr2_cfg = '0;
    logic cke, rfsh_en, init_done;
    logic [2:0] cmd;
    logic [1:0] ba;
    logic [AW-1:0] addr;
    logic [4:0] bank_pos;

    int checks = 0, fails = 0;
    int cyc = 0;
    int ev_n = 0, cke_rise = -1, rfsh_rise = -1, done_rise = -1, bad_cke = 0, drops = 0;
    int ev_cyc [0:31];
    logic [2:0] ev_cmd [0:31];
    logic [1:0] ev_ba [0:31];
    logic [AW-1:0] ev_addr [0:31];

    always #2 clk = ~clk;

    ddr2_bringup_seq #(.ADDR_W(AW), .CLK_PERIOD_PS(PS), .PWRUP_NS(PWR_NS),
                       .SETTLE_NS(SET_NS)) uut (
        .clk(clk), .rst(rst), .col_code(col_code), .row_code(row_code),
        .seq_map(seq_map), .half_bus(half_bus), .mr_cfg(mr_cfg),
        .emr1_cfg(emr1_cfg), .emr2_cfg(emr2_cfg), .cke(cke), .cmd(cmd),
        .ba(ba), .addr(addr), .bank_pos(bank_pos), .rfsh_en(rfsh_en),
        .init_done(init_done));

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd != NOP) begin
                if (!cke) bad_cke++;
                if (ev_n < 32) begin
                    ev_cyc[ev_n] = cyc; ev_cmd[ev_n] = cmd;
                    ev_ba[ev_n] = ba;   ev_addr[ev_n] = addr;
                end
                ev_n++;
            end
            if (cke && cke_rise < 0) cke_rise = cyc;
            if (!cke && cke_rise >= 0) drops++;
            if (rfsh_en && rfsh_rise < 0) rfsh_rise = cyc;
            if (!rfsh_en && rfsh_rise >= 0) drops++;
            if (init_done && done_rise < 0) done_rise = cyc;
            if (!init_done && done_rise >= 0) drops++;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 cke", cke, 0);
        chk("R1 cmd", cmd, NOP);
        chk("R1 rfsh_en", rfsh_en, 0);
        chk("R1 init_done", init_done, 0);
        ev_n = 0; cke_rise = -1; rfsh_rise = -1; done_rise = -1; bad_cke = 0; drops = 0;
        rst = 1'b0;
    endtask

    function automatic logic [2:0] exp_cmd(int i);
        case (i) 0, 5: return PRE; 6, 7: return REF; default: return MRS; endcase
    endfunction

    function automatic logic [1:0] exp_ba(int i);
        case (i) 1: return 2; 2: return 3; 3, 9, 10: return 1; default: return 0; endcase
    endfunction

    function automatic logic [AW-1:0] exp_addr(int i);
        logic [AW-1:0] base;
        base = emr1_cfg & ~(AW'(7) << 7);
        case (i)
            0, 5:  return AW'(1) << 10;
            1:     return emr2_cfg;
            3, 10: return base;
            4:     return mr_cfg | (AW'(1) << 8);
            8:     return mr_cfg & ~(AW'(1) << 8);
            9:     return base | (AW'(7) << 7);
            default: return '0;
        endcase
    endfunction

    function automatic int exp_gap(int i);
        case (i) 3: return E_DLL; 5: return E_PRE; 6, 7: return E_RFC; default: return E_MRD; endcase
    endfunction

    function automatic int exp_bpos(int c, int r, int s, int h);
        return c + 9 + (s != 0 ? r + 11 : 0) + (h != 0 ? 2 : 1);
    endfunction

    task automatic full_run();
        int guard;
        do_reset();
        guard = 0;
        while (!init_done && guard < 20000) begin @(negedge clk); guard++; end
        chk("R8 init_done reached", init_done, 1);
        repeat (30) @(negedge clk);
        chk("R10 quiet after done cmd", cmd, NOP);
        chk("R10 cke after done", cke, 1);
        chk("R2 cke rise cycle", cke_rise, E_PWR);
        chk("R2 no command while cke low", bad_cke, 0);
        chk("R3 command count", ev_n, 11);
        chk("R7 no drops of level outputs", drops, 0);
        if (ev_n == 11) begin
            chk("R6 cke to first precharge", ev_cyc[0] - cke_rise, E_CKE);
            for (int i = 0; i < 11; i++) begin
                chk($sformatf("R3 cmd %0d", i), ev_cmd[i], exp_cmd(i));
                chk($sformatf("R4 ba %0d", i), ev_ba[i], exp_ba(i));
                chk($sformatf("R5 addr %0d", i), ev_addr[i], exp_addr(i));
                if (i < 10)
                    chk($sformatf("R6 gap after %0d", i), ev_cyc[i+1] - ev_cyc[i], exp_gap(i));
            end
            chk("R8 rfsh_en delay", rfsh_rise - ev_cyc[10], E_MRD);
        end
        chk("R8 settle delay", done_rise - rfsh_rise, E_SET);
        chk("R9 bank_pos", bank_pos, exp_bpos(col_code, row_code, seq_map, half_bus));
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        // Directed: all-zero configuration.
        full_run();
        // Directed: all-ones, exercises the bit-8 and bits 9:7 overrides.
        mr_cfg = '1; emr1_cfg = '1; emr2_cfg = '1;
        col_code = 2'd3; row_code = 2'd3; seq_map = 1'b1; half_bus = 1'b1;
        full_run();
        // R10: reset in the middle of the command phase restarts everything.
        do_reset();
        while (ev_n < 4) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            mr_cfg = AW'($urandom); emr1_cfg = AW'($urandom); emr2_cfg = AW'($urandom);
            col_code = 2'($urandom); row_code = 2'($urandom);
            seq_map = 1'($urandom); half_bus = 1'($urandom);
            full_run();
        end
        // R9: extra combinational bank-position patterns.
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            col_code = 2'(k); row_code = 2'(k >> 2); seq_map = 1'($urandom); half_bus = 1'($urandom);
            #1;
            chk("R9 bank_pos sweep", bank_pos, exp_bpos(col_code, row_code, seq_map, half_bus));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule